// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It takes a stream of 32-bit trace words, qualified by a valid strobe, and stores them in an on-chip RAM that it uses as a ring. When the write pointer runs past the last location it wraps back to zero without stalling, and a sticky status flag records the wrap. Once the flag is set, the oldest valid word is at the write pointer. While the flag is clear, valid data starts at location 0.

Software manages the block through a simple memory-mapped register port that carries 32-bit accesses. Through it, software can:
- read the RAM depth and the status;
- load the read and write pointers;
- read the captured words through an auto-advancing data window, or write words through one;
- program a post-trigger word count;
- enable capture;
- request a flush, which can also stop the capture path.

Every register write is blocked until a key is written to a lock register.

Capture can end in two ways. It can stop after a programmed number of words that follow a trigger pulse. It can also stop when a manual flush completes. Either way a stopped flag is raised, and it stays up until software re-enables capture.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset:
  - the block is locked, and control, pointers, trigger count and flush control read 0;
  - status reads 0 and flush status reads 2 (bit 1, stopped, set);
  - the depth register at 0x004 reads DEPTH.
- R2: Writing 32'hC5ACCE55 to offset 0xFB0 unlocks the block, and writing any other value there locks it. While the block is locked, writes to all other offsets are ignored. Reads work whether the block is locked or not.
- R3: The data for a read request appears on bus_rdata after the clock edge that samples the request. It holds that value until the next read.
- R4: A write to offset 0x024 stores the write data at the write pointer and advances the write pointer by one, modulo DEPTH.
- R5: A read of offset 0x010 returns the word at the read pointer and advances the read pointer by one, modulo DEPTH. DEPTH reads in a row return every location in ring order.
- R6: Writes to offsets 0x014 (read pointer) and 0x018 (write pointer) load the low log2(DEPTH) bits of the data. A write-pointer load clears the wrap flag.
- R7: The status register at 0x00C has two flags:
  - bit 0 is the wrap flag, set when the write pointer advances from DEPTH-1 to 0;
  - bit 3 reads 1 when the write pointer is not a multiple of 4, which marks a partial 4-word frame.
- R8: Setting bit 0 of control (0x020) enables capture. Each valid trace word is then stored at the write pointer, which advances. While capture is off, flush status (0x300) bit 1 reads 1. If a write to 0x024 or 0x018 lands in the same cycle as a trace word, the software access wins and the trace word is dropped.
- R9: Writing 1 to bit 6 of flush control (0x304) starts a flush. Bit 6 reads 1 until the first cycle in which no trace word is accepted, and then clears itself.
- R10: Bits 0, 12 and 13 of flush control hold their written values. All other bits, except bit 6, read 0.
- R11: With flush-control bit 12 set, a completing flush stops capture and flush status bit 1 reads 1, even with control bit 0 still set.
- R12: Trigger stop, controlled by flush-control bit 13:
  - with bit 13 set, a trigger pulse during capture arms a stop;
  - exactly the number of further words held in the trigger register (0x01C) is then accepted, after which capture stops and flush status bit 1 reads 1;
  - with bit 13 clear, the trigger input is ignored.
- R13: A control write that sets bit 0 while capture is disabled clears a latched stop and disarms the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access request, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the edge that takes the read |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger pulse |

## Verification
The bound checker watches the following on every cycle:
- that each window access moves its pointer by exactly one;
- that the wrap flag rises when the write pointer rolls over and falls on a pointer load;
- that no trace word is accepted while stopped or while a software write to the data window or write pointer wins;
- that locked writes leave control and trigger state untouched, that a pending flush persists while words keep arriving, and that read data holds between reads.

Only the bench scenarios can show the end-to-end behaviours:
- that ring contents come back in order after a full wrap;
- the exact number of words accepted after a trigger, including a zero count;
- that a flush with stop-on-flush set halts capture while control still reads enabled;
- that the frame-alignment flag is correct.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int FRAME_WORDS = 4;

  localparam logic [ADDR_W-1:0] OFS_DEPTH = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RDAT  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RPTR  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_WPTR  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_WDAT  = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_FSTAT = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_FCTL  = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hFB0;

  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hC5ACCE55;

  // flush-control bit positions
  localparam int FC_FMT    = 0;
  localparam int FC_FLUSH  = 6;
  localparam int FC_STOPFL = 12;
  localparam int FC_STOPTG = 13;

  typedef struct packed {
    logic stop_on_trig;
    logic stop_on_flush;
    logic fmt_en;
  } stop_cfg_t;
endpackage

// File: rtl/trs_rst_sync.sv
module trs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/trs_regs.sv
module trs_regs
  import trs_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int FAW  = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] ram_q,
  input  logic [AW-1:0]     rptr,
  input  logic [AW-1:0]     wptr,
  input  logic              wrapped,
  input  logic              flush_pend,
  input  logic              stopped,
  output logic              unlocked,
  output logic              ctl_en,
  output logic              ctl_start,
  output stop_cfg_t         cfg,
  output logic [WORD_W-1:0] trg_val,
  output logic              flush_req,
  output logic              wr_wdat,
  output logic              wr_rptr,
  output logic              wr_wptr,
  output logic              rd_rdat
);
  logic              unlocked_q, unlocked_d;
  logic              ctl_en_q, ctl_en_d;
  stop_cfg_t         cfg_q, cfg_d;
  logic [WORD_W-1:0] trg_q, trg_d;
  logic [WORD_W-1:0] rdata_q, rdata_d, rmux;
  logic              rd_ram_q, rd_ram_d;
  logic              is_wr, is_rd, wr_ok;

  always_comb begin
    is_wr = bus_sel & bus_wr;
    is_rd = bus_sel & ~bus_wr;
    wr_ok = is_wr & unlocked_q;

    wr_wdat   = wr_ok & (bus_addr == OFS_WDAT);
    wr_rptr   = wr_ok & (bus_addr == OFS_RPTR);
    wr_wptr   = wr_ok & (bus_addr == OFS_WPTR);
    rd_rdat   = is_rd & (bus_addr == OFS_RDAT);
    flush_req = wr_ok & (bus_addr == OFS_FCTL) & bus_wdata[FC_FLUSH];
    ctl_start = wr_ok & (bus_addr == OFS_CTRL) & bus_wdata[0] & ~ctl_en_q;

    unlocked_d = unlocked_q;
    if (is_wr && bus_addr == OFS_LOCK) unlocked_d = (bus_wdata == UNLOCK_KEY);

    ctl_en_d = ctl_en_q;
    if (wr_ok && bus_addr == OFS_CTRL) ctl_en_d = bus_wdata[0];

    cfg_d = cfg_q;
    if (wr_ok && bus_addr == OFS_FCTL) begin
      cfg_d.fmt_en        = bus_wdata[FC_FMT];
      cfg_d.stop_on_flush = bus_wdata[FC_STOPFL];
      cfg_d.stop_on_trig  = bus_wdata[FC_STOPTG];
    end

    trg_d = trg_q;
    if (wr_ok && bus_addr == OFS_TRIG) trg_d = bus_wdata;
  end

  // register read multiplexer
  always_comb begin
    rmux = '0;
    unique case (bus_addr)
      OFS_DEPTH: rmux = WORD_W'(DEPTH);
      OFS_STAT: begin
        rmux[0] = wrapped;
        rmux[3] = |wptr[FAW-1:0];
      end
      OFS_RPTR:  rmux = WORD_W'(rptr);
      OFS_WPTR:  rmux = WORD_W'(wptr);
      OFS_TRIG:  rmux = trg_q;
      OFS_CTRL:  rmux[0] = ctl_en_q;
      OFS_FSTAT: rmux[1] = stopped;
      OFS_FCTL: begin
        rmux[FC_FMT]    = cfg_q.fmt_en;
        rmux[FC_FLUSH]  = flush_pend;
        rmux[FC_STOPFL] = cfg_q.stop_on_flush;
        rmux[FC_STOPTG] = cfg_q.stop_on_trig;
      end
      default:   rmux = '0;
    endcase
  end

  always_comb begin
    rdata_d  = is_rd ? rmux : rdata_q;
    rd_ram_d = is_rd ? (bus_addr == OFS_RDAT) : rd_ram_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      ctl_en_q   <= 1'b0;
      cfg_q      <= '0;
      trg_q      <= '0;
      rdata_q    <= '0;
      rd_ram_q   <= 1'b0;
    end else begin
      unlocked_q <= unlocked_d;
      ctl_en_q   <= ctl_en_d;
      cfg_q      <= cfg_d;
      trg_q      <= trg_d;
      rdata_q    <= rdata_d;
      rd_ram_q   <= rd_ram_d;
    end
  end

  assign bus_rdata = rd_ram_q ? ram_q : rdata_q;
  assign unlocked  = unlocked_q;
  assign ctl_en    = ctl_en_q;
  assign cfg       = cfg_q;
  assign trg_val   = trg_q;
endmodule

// File: rtl/trs_capture.sv
module trs_capture
  import trs_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_valid,
  input  logic [WORD_W-1:0] trc_data,
  input  logic              trc_trigger,
  input  logic              wr_wdat,
  input  logic              wr_rptr,
  input  logic              wr_wptr,
  input  logic              rd_rdat,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              ctl_en,
  input  logic              ctl_start,
  input  logic              stop_on_flush,
  input  logic              stop_on_trig,
  input  logic [WORD_W-1:0] trg_val,
  input  logic              flush_req,
  output logic [AW-1:0]     rptr,
  output logic [AW-1:0]     wptr,
  output logic              wrapped,
  output logic              flush_pend,
  output logic              stopped,
  output logic              accept,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic              ram_re,
  output logic [AW-1:0]     ram_raddr
);
  logic [AW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic              wrap_q, wrap_d, flush_q, flush_d;
  logic              halt_q, halt_d, armed_q, armed_d;
  logic [WORD_W-1:0] remain_q, remain_d;
  logic              capturing, exhausted, advance, flush_done, trig_hit;

  always_comb begin
    capturing  = ctl_en & ~halt_q;
    exhausted  = armed_q & (remain_q == '0);
    accept     = trc_valid & capturing & ~exhausted & ~wr_wdat & ~wr_wptr;
    advance    = accept | wr_wdat;
    flush_done = flush_q & ~accept;
    trig_hit   = trc_trigger & capturing & stop_on_trig & ~armed_q;

    wptr_d = wptr_q;
    wrap_d = wrap_q;
    if (wr_wptr) begin
      wptr_d = bus_wdata[AW-1:0];
      wrap_d = 1'b0;
    end else if (advance) begin
      wptr_d = wptr_q + AW'(1);
      if (wptr_q == AW'(DEPTH - 1)) wrap_d = 1'b1;
    end

    rptr_d = rptr_q;
    if (wr_rptr)      rptr_d = bus_wdata[AW-1:0];
    else if (rd_rdat) rptr_d = rptr_q + AW'(1);

    flush_d = flush_req | (flush_q & accept);

    armed_d  = armed_q;
    remain_d = remain_q;
    if (ctl_start) begin
      armed_d = 1'b0;
    end else if (trig_hit) begin
      armed_d  = 1'b1;
      remain_d = trg_val;
    end else if (armed_q && accept) begin
      remain_d = remain_q - WORD_W'(1);
    end

    halt_d = halt_q;
    if (ctl_start) halt_d = 1'b0;
    else if ((flush_done && stop_on_flush) || (exhausted && stop_on_trig)) halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      wrap_q   <= 1'b0;
      flush_q  <= 1'b0;
      halt_q   <= 1'b0;
      armed_q  <= 1'b0;
      remain_q <= '0;
    end else begin
      wptr_q   <= wptr_d;
      rptr_q   <= rptr_d;
      wrap_q   <= wrap_d;
      flush_q  <= flush_d;
      halt_q   <= halt_d;
      armed_q  <= armed_d;
      remain_q <= remain_d;
    end
  end

  assign rptr       = rptr_q;
  assign wptr       = wptr_q;
  assign wrapped    = wrap_q;
  assign flush_pend = flush_q;
  assign stopped    = ~ctl_en | halt_q;
  assign ram_we     = advance;
  assign ram_waddr  = wptr_q;
  assign ram_wdata  = wr_wdat ? bus_wdata : trc_data;
  assign ram_re     = rd_rdat;
  assign ram_raddr  = rptr_q;
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              trc_valid,
  input  logic [WORD_W-1:0] trc_data,
  input  logic              trc_trigger
);
  logic              srst_n;
  logic [WORD_W-1:0] ram_q, trg_val, ram_wdata;
  logic [AW-1:0]     rptr, wptr, ram_waddr, ram_raddr;
  logic              wrapped, flush_pend, stopped, accept;
  logic              unlocked, ctl_en, ctl_start, flush_req;
  logic              wr_wdat, wr_rptr, wr_wptr, rd_rdat, ram_we, ram_re;
  stop_cfg_t         cfg;

  trs_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  trs_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(srst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_q(ram_q),
    .rptr(rptr), .wptr(wptr), .wrapped(wrapped), .flush_pend(flush_pend),
    .stopped(stopped), .unlocked(unlocked), .ctl_en(ctl_en),
    .ctl_start(ctl_start), .cfg(cfg), .trg_val(trg_val),
    .flush_req(flush_req), .wr_wdat(wr_wdat), .wr_rptr(wr_rptr),
    .wr_wptr(wr_wptr), .rd_rdat(rd_rdat)
  );

  trs_capture #(.DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst_n(srst_n),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger),
    .wr_wdat(wr_wdat), .wr_rptr(wr_rptr), .wr_wptr(wr_wptr),
    .rd_rdat(rd_rdat), .bus_wdata(bus_wdata), .ctl_en(ctl_en),
    .ctl_start(ctl_start), .stop_on_flush(cfg.stop_on_flush),
    .stop_on_trig(cfg.stop_on_trig), .trg_val(trg_val),
    .flush_req(flush_req), .rptr(rptr), .wptr(wptr), .wrapped(wrapped),
    .flush_pend(flush_pend), .stopped(stopped), .accept(accept),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr)
  );

  trs_ram #(.DEPTH(DEPTH), .DW(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .q(ram_q)
  );
endmodule

// File: rtl/trs_checker.sv
module trs_checker
  import trs_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              unlocked,
  input logic              ctl_en,
  input logic [WORD_W-1:0] trg_val,
  input logic              wr_wdat,
  input logic              wr_wptr,
  input logic              rd_rdat,
  input logic              accept,
  input logic [AW-1:0]     wptr,
  input logic [AW-1:0]     rptr,
  input logic              wrapped,
  input logic              flush_pend,
  input logic              stopped
);
  a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_sel && bus_wr && bus_addr != OFS_LOCK) |=> ($stable(ctl_en) && $stable(trg_val)));

  a_r3_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  a_r4_wdat_advances: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wdat |=> (wptr == $past(wptr) + AW'(1)));

  a_r5_rdat_advances: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rdat |=> (rptr == $past(rptr) + AW'(1)));

  a_r6_load_clears_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wptr |=> !wrapped);

  a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((accept || wr_wdat) && !wr_wptr && wptr == AW'(DEPTH - 1)) |=> wrapped);

  a_r8_no_capture_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !accept);

  a_r8_software_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wdat || wr_wptr) |-> !accept);

  a_r9_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && accept) |=> flush_pend);
endmodule

bind trace_ring_sink trs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(srst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .unlocked(unlocked),
  .ctl_en(ctl_en), .trg_val(trg_val), .wr_wdat(wr_wdat), .wr_wptr(wr_wptr),
  .rd_rdat(rd_rdat), .accept(accept), .wptr(wptr), .rptr(rptr),
  .wrapped(wrapped), .flush_pend(flush_pend), .stopped(stopped)
);

// File: tb/trace_ring_sink_tb.sv
module trace_ring_sink_tb;
  localparam int D = 16;
  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDAT = 12'h010,
    A_RPTR = 12'h014, A_WPTR = 12'h018, A_TRIG = 12'h01C, A_CTRL = 12'h020,
    A_WDAT = 12'h024, A_FSTAT = 12'h300, A_FCTL = 12'h304, A_LOCK = 12'hFB0;

  logic clk, rst_n, bus_sel, bus_wr, trc_valid, trc_trigger;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, trc_data;
  int checks, errors;
  logic rd_seen;
  logic [31:0] exp_q[$];
  string tag_q[$];

  trace_ring_sink #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int n, input logic [31:0] base, input logic trig_first);
    for (int i = 0; i < n; i++) begin
      trc_valid = 1'b1; trc_data = base + 32'(i); trc_trigger = trig_first && (i == 0);
      @(negedge clk);
    end
    trc_valid = 1'b0; trc_trigger = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    trc_valid = 0; trc_data = '0; trc_trigger = 0; rst_n = 0;
    idle(3); rst_n = 1; idle(4);

    // R1 reset state
    bus_read(A_DEPTH, 32'd16, "R1 depth");
    bus_read(A_CTRL, 0, "R1 ctrl");
    bus_read(A_STAT, 0, "R1 status");
    bus_read(A_FSTAT, 32'h2, "R1 stopped");
    bus_read(A_WPTR, 0, "R1 wptr");
    bus_read(A_FCTL, 0, "R1 fctl");

    // R2 lock
    bus_write(A_CTRL, 1);
    bus_write(A_WPTR, 5);
    bus_read(A_CTRL, 0, "R2 locked ctrl");
    bus_read(A_WPTR, 0, "R2 locked wptr");
    bus_write(A_LOCK, 32'hC5ACCE55);
    bus_write(A_TRIG, 9);
    bus_read(A_TRIG, 9, "R2 unlocked trig");
    bus_write(A_LOCK, 0);
    bus_write(A_TRIG, 5);
    bus_read(A_TRIG, 9, "R2 relocked trig");
    bus_write(A_LOCK, 32'hC5ACCE55);

    // R4/R5/R7 full ring fill and readback
    bus_write(A_WPTR, 0);
    for (int i = 0; i < D; i++) bus_write(A_WDAT, 32'hA000_0000 + 32'(i));
    bus_read(A_WPTR, 0, "R4 wptr wrapped to 0");
    bus_read(A_STAT, 1, "R7 wrap flag");
    bus_write(A_RPTR, 0);
    for (int i = 0; i < D; i++) bus_read(A_RDAT, 32'hA000_0000 + 32'(i), "R5 ring order");
    bus_read(A_RPTR, 0, "R5 rptr wrapped");

    // R6/R7 pointer loads and frame flag
    bus_write(A_WPTR, 0);
    bus_read(A_STAT, 0, "R6 load clears wrap");
    bus_write(A_WDAT, 32'hB0);
    bus_read(A_STAT, 32'h8, "R7 partial frame");
    bus_write(A_RPTR, 32'h23);
    bus_read(A_RPTR, 3, "R6 rptr low bits");
    bus_read(A_RDAT, 32'hA000_0003, "R5 read at 3");
    idle(4);
    check("R3 rdata held", bus_rdata, 32'hA000_0003);
    bus_read(A_RPTR, 4, "R5 rptr advanced");

    // R8 capture
    bus_write(A_WPTR, 4);
    bus_write(A_CTRL, 1);
    bus_read(A_FSTAT, 0, "R8 capturing");
    burst(3, 32'hC0, 1'b0);
    bus_read(A_WPTR, 7, "R8 wptr after capture");
    bus_write(A_CTRL, 0);
    bus_read(A_FSTAT, 2, "R8 stopped when off");
    burst(2, 32'hCC, 1'b0);
    bus_read(A_WPTR, 7, "R8 no capture when off");
    bus_write(A_RPTR, 4);
    for (int i = 0; i < 3; i++) bus_read(A_RDAT, 32'hC0 + 32'(i), "R8 captured word");
    // R8 software write wins over trace word
    bus_write(A_CTRL, 1);
    trc_valid = 1; trc_data = 32'hD0;
    bus_write(A_WDAT, 32'hE0);
    trc_valid = 0;
    bus_write(A_CTRL, 0);
    bus_read(A_WPTR, 8, "R8 one advance");
    bus_write(A_RPTR, 7);
    bus_read(A_RDAT, 32'hE0, "R8 software word stored");
    bus_read(A_RDAT, 32'hA000_0008, "R8 trace word dropped");

    // R10 flush control bits
    bus_write(A_FCTL, 32'hFFFF_BFBF);
    bus_read(A_FCTL, 32'h3001, "R10 fctl bits");
    bus_write(A_FCTL, 0);

    // R9 flush held while words arrive, no stop without bit 12
    bus_write(A_CTRL, 1);
    trc_valid = 1; trc_data = 32'hF0;
    bus_write(A_FCTL, 32'h40);
    bus_read(A_FCTL, 32'h40, "R9 flush pending");
    bus_read(A_FCTL, 32'h40, "R9 flush still pending");
    trc_valid = 0;
    idle(2);
    bus_read(A_FCTL, 0, "R9 flush cleared");
    bus_read(A_FSTAT, 0, "R9 no stop without bit12");

    // R11 stop on flush
    bus_write(A_CTRL, 0);
    bus_write(A_FCTL, 32'h1000);
    bus_write(A_WPTR, 0);
    bus_write(A_CTRL, 1);
    trc_valid = 1; trc_data = 32'h11;
    bus_write(A_FCTL, 32'h1040);
    bus_read(A_FCTL, 32'h1040, "R11 flush pending");
    trc_valid = 0;
    idle(2);
    bus_read(A_FSTAT, 2, "R11 stopped after flush");
    bus_read(A_CTRL, 1, "R11 ctrl still set");
    burst(2, 32'h22, 1'b0);
    bus_read(A_WPTR, 2, "R11 no words after stop");
    bus_read(A_FCTL, 32'h1000, "R11 flush self-cleared");
    bus_write(A_CTRL, 0);
    bus_write(A_FCTL, 0);
    bus_write(A_CTRL, 1);
    bus_read(A_FSTAT, 0, "R13 restart clears stop");

    // R12 trigger stop after 3 words
    bus_write(A_CTRL, 0);
    bus_write(A_FCTL, 32'h2000);
    bus_write(A_TRIG, 3);
    bus_write(A_WPTR, 0);
    bus_write(A_CTRL, 1);
    burst(7, 32'h700, 1'b1);
    idle(1);
    bus_read(A_WPTR, 4, "R12 trigger word plus 3");
    bus_read(A_FSTAT, 2, "R12 stopped");
    bus_write(A_RPTR, 0);
    for (int i = 0; i < 4; i++) bus_read(A_RDAT, 32'h700 + 32'(i), "R12 kept words");

    // R12 trigger ignored with bit 13 clear
    bus_write(A_CTRL, 0);
    bus_write(A_FCTL, 0);
    bus_write(A_CTRL, 1);
    bus_write(A_WPTR, 0);
    burst(7, 32'h800, 1'b1);
    bus_read(A_WPTR, 7, "R12 trigger ignored");
    bus_read(A_FSTAT, 0, "R12 not stopped");

    // R12 zero count, then R13 restart disarms
    bus_write(A_CTRL, 0);
    bus_write(A_FCTL, 32'h2000);
    bus_write(A_TRIG, 0);
    bus_write(A_WPTR, 0);
    bus_write(A_CTRL, 1);
    burst(3, 32'h900, 1'b1);
    bus_read(A_WPTR, 1, "R12 zero count");
    bus_read(A_FSTAT, 2, "R12 zero count stopped");
    bus_write(A_CTRL, 0);
    bus_write(A_CTRL, 1);
    bus_read(A_FSTAT, 0, "R13 restart");
    burst(2, 32'hA00, 1'b0);
    bus_read(A_WPTR, 3, "R13 disarmed capture");

    idle(4);
    if (exp_q.size() != 0) check("scoreboard drained", 32'(exp_q.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule